// File: doc/BRIEF.md
# External Interrupt Collector

This block gathers a bank of asynchronous interrupt request lines, turns each low-to-high transition into a sticky pending bit, and raises one level request toward the processor while any pending line is enabled and the processor's global interrupt enable is on. Software sees two registers through a small read/write port. The pending register is cleared by writing zeros to the bits to drop, and the enable register selects which lines may request. The two lowest lines ignore the enable register and always request.

Every arrival also produces a one-cycle wake pulse, which the power manager uses to clear its doze and sleep enables. When the controller is switched off, the registers are bypassed. An arrival then produces a one-cycle request pulse, gated only by the global enable, and the pending register keeps its value.

Top module: `extint_ctrl`

## Requirements
- R1: After synchronous reset, the pending register, enable register, `irq_req`, `wake_pulse` and `reg_rdata` are all zero.
- R2: With `ctrl_en` high, a low-to-high transition on `irq_in[i]` sets pending bit i three clock edges after the input changes. The first two edges go to two-flop synchronization and the third to edge detection. A line that stays high does not set its bit again after the bit is cleared; a new rising edge is needed.
- R3: A write with `reg_sel`=0 updates the pending register as pending AND `reg_wdata`. A zero bit clears the pending bit and a one bit leaves it unchanged. An arrival on the same edge as the write wins, and its bit ends up set.
- R4: A write with `reg_sel`=1 loads the enable register from `reg_wdata`. `reg_rdata` returns the register chosen by `reg_sel` (0 pending, 1 enable) as it stood before the edge, one edge after selection.
- R5: With `ctrl_en` high, `irq_req` is registered. It is high, and stays high, exactly when `gie` was high and (pending AND (enable OR lines 0..1)) was nonzero at the previous edge. A pending line whose enable bit is zero does not request.
- R6: Lines 0 and 1 request whenever they are pending, whatever their enable bits.
- R7: With `gie` low, `irq_req` stays low, but arrivals are still recorded in the pending register.
- R8: Each arrival drives `wake_pulse` high for exactly one cycle, on the same edge that records it. This holds whether the controller is enabled or not.
- R9: With `ctrl_en` low, an arrival raises `irq_req` for exactly one cycle, on the edge after detection, if `gie` is high. The pending register is not changed by the arrival.
- R10: Clearing the last qualifying pending bit drops `irq_req` one edge after the write, so a request that has waited is dropped if the pending bits have been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_en | input | 1 | Controller enable; low bypasses the registers |
| gie | input | 1 | Global interrupt enable from the processor |
| irq_in | input | NLINES | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 pending, 1 enable |
| reg_wdata | input | NLINES | Register write data |
| reg_rdata | output | NLINES | Registered read data |
| irq_req | output | 1 | Interrupt request to the processor |
| wake_pulse | output | 1 | One-cycle pulse that clears doze and sleep enables |

## Verification
The bench holds a line high across a clear of its pending bit. A design that detects the level instead of the edge would set the bit again at once and keep requesting. It times an arrival to land on the same edge as a clear-all write; a design that lets the write win would lose that interrupt. It raises line 1 with its enable bit clear, where a design without the fixed override would stay silent. With the controller disabled, it checks for a one-cycle request and an unchanged pending register. A design that still used its registers would either leave the request held high or record the line.

// File: rtl/extint_pkg.sv
package extint_pkg;
  typedef enum logic {
    SEL_PENDING = 1'b0,
    SEL_ENABLE  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/extint_sync_edge.sv
module extint_sync_edge #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] seen_lvl;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
      seen_lvl <= '0;
    end else begin
      chain[0] <= raw;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
      seen_lvl <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~seen_lvl;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ((rise & $past(rise)) == '0)); // R2
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_en,
  input  logic [W-1:0] rise,
  input  logic         reg_wr,
  input  logic         reg_sel,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] pending,
  output logic [W-1:0] enable,
  output logic [W-1:0] reg_rdata
);
  reg_sel_e     sel;
  logic         wr_pend;
  logic         wr_enab;
  logic [W-1:0] pend_base;
  logic [W-1:0] arrivals;

  assign sel       = reg_sel_e'(reg_sel);
  assign wr_pend   = reg_wr && (sel == SEL_PENDING);
  assign wr_enab   = reg_wr && (sel == SEL_ENABLE);
  assign pend_base = wr_pend ? (pending & reg_wdata) : pending;
  assign arrivals  = ctrl_en ? rise : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      enable    <= '0;
      reg_rdata <= '0;
    end else begin
      pending   <= pend_base | arrivals;
      if (wr_enab) enable <= reg_wdata;
      reg_rdata <= (sel == SEL_ENABLE) ? enable : pending;
    end
  end

  AST_ARRIVAL_SETS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && (rise != '0)) |=> ((pending & $past(rise)) == $past(rise))); // R2
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_pend && (rise == '0)) |=> ((pending & ~$past(reg_wdata)) == '0)); // R3
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !wr_pend) |=> (pending == $past(pending))); // R9
endmodule

// File: rtl/extint_req.sv
module extint_req #(
  parameter int W     = 32,
  parameter int FIXED = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ctrl_en,
  input  logic         gie,
  input  logic [W-1:0] pending,
  input  logic [W-1:0] enable,
  input  logic [W-1:0] rise,
  output logic         irq_req,
  output logic         wake_pulse
);
  logic [W-1:0] fixed_mask;
  logic         qualified;
  logic         any_rise;

  for (genvar i = 0; i < W; i++) begin : g_fixed
    assign fixed_mask[i] = (i < FIXED);
  end

  assign qualified = (pending & (enable | fixed_mask)) != '0;
  assign any_rise  = rise != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req    <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      irq_req    <= gie && (ctrl_en ? qualified : any_rise);
      wake_pulse <= any_rise;
    end
  end

  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(gie)); // R7
  AST_FIXED_LINES: assert property (@(posedge clk) disable iff (rst)
    (ctrl_en && gie && ((pending & fixed_mask) != '0)) |=> irq_req); // R6
endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl #(
  parameter int NLINES      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FIXED_LINES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_en,
  input  logic              gie,
  input  logic [NLINES-1:0] irq_in,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  output logic              irq_req,
  output logic              wake_pulse
);
  logic [NLINES-1:0] rise;
  logic [NLINES-1:0] pending;
  logic [NLINES-1:0] enable;

  extint_sync_edge #(.W(NLINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .raw(irq_in), .rise(rise)
  );

  extint_regs #(.W(NLINES)) u_regs (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .rise(rise),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .pending(pending), .enable(enable), .reg_rdata(reg_rdata)
  );

  extint_req #(.W(NLINES), .FIXED(FIXED_LINES)) u_req (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .gie(gie),
    .pending(pending), .enable(enable), .rise(rise),
    .irq_req(irq_req), .wake_pulse(wake_pulse)
  );

  AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse); // R8
  AST_OFF_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && $past(!ctrl_en) && irq_req) |=> !irq_req); // R9
endmodule

// File: tb/extint_ctrl_test.sv
`timescale 1ns/1ps
module extint_ctrl_test;
  localparam int W = 32;
  localparam int K_REQ = 0, K_WAKE = 1, K_RD = 2;

  logic clk = 1'b0, rst = 1'b1, ctrl_en = 1'b0, gie = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0;
  logic [W-1:0] irq_in = '0, reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq_req, wake_pulse;

  extint_ctrl #(.NLINES(W)) uut (
    .clk(clk), .rst(rst), .ctrl_en(ctrl_en), .gie(gie), .irq_in(irq_in),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_req(irq_req), .wake_pulse(wake_pulse)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int           at;
    int           kind;
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  exp_t sbq[$];
  int checks = 0, errors = 0;
  bit done = 0;
  exp_t mon_e;
  logic [W-1:0] mon_act;

  task automatic push(int dly, int kind, logic [W-1:0] val, string tag);
    exp_t e;
    int pos;
    e.at = cyc + dly; e.kind = kind; e.val = val; e.tag = tag;
    pos = sbq.size();
    for (int i = 0; i < sbq.size(); i++) begin
      if (sbq[i].at > e.at) begin pos = i; break; end
    end
    sbq.insert(pos, e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [W-1:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step(1);
    reg_wr = 1'b0;
  endtask

  // monitor: compares scoreboard items in the cycle they fall due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].at <= cyc) begin
      mon_e = sbq.pop_front();
      case (mon_e.kind)
        K_REQ:   mon_act = {{(W-1){1'b0}}, irq_req};
        K_WAKE:  mon_act = {{(W-1){1'b0}}, wake_pulse};
        default: mon_act = reg_rdata;
      endcase
      checks++;
      if (mon_act !== mon_e.val) begin
        errors++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 mon_e.tag, mon_e.kind, cyc, mon_act, mon_e.val);
      end
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    // R1 reset state
    push(1, K_REQ, 0, "R1 irq_req"); push(1, K_WAKE, 0, "R1 wake");
    push(1, K_RD, 0, "R1 pending");
    step(1);
    reg_sel = 1'b1;
    push(1, K_RD, 0, "R1 enable");
    step(2);
    // R4 enable register write and readback
    wr(1'b1, 32'hA5A5_0010);
    push(1, K_RD, 32'hA5A5_0010, "R4 enable readback");
    step(2);
    ctrl_en = 1'b1; gie = 1'b1; reg_sel = 1'b0;
    step(1);
    // R5 enabled line 4 requests, R8 wake pulse
    irq_in[4] = 1'b1;
    push(3, K_WAKE, 1, "R8 wake on arrival"); push(4, K_WAKE, 0, "R8 one cycle");
    push(3, K_REQ, 0, "R5 not yet");          push(4, K_REQ, 1, "R5 request");
    push(4, K_RD, 32'h10, "R2 pending set");
    step(6);
    push(1, K_REQ, 1, "R5 level held");
    step(2);
    // R10 clear drops request; R2 held-high line does not re-set
    wr(1'b0, ~32'h10);
    push(1, K_REQ, 0, "R10 request drops"); push(1, K_RD, 0, "R3 zero clears");
    step(5);
    push(1, K_RD, 0, "R2 no re-set while high"); push(1, K_REQ, 0, "R2 no request");
    step(2);
    // R5 disabled-enable line 5 is pending but silent
    irq_in[5] = 1'b1;
    push(3, K_WAKE, 1, "R8 wake line 5"); push(4, K_RD, 32'h20, "R2 line 5 pending");
    push(5, K_REQ, 0, "R5 masked line silent");
    step(6);
    // R6 line 1 requests despite its enable bit clear
    irq_in[1] = 1'b1;
    push(4, K_REQ, 1, "R6 fixed line requests"); push(5, K_RD, 32'h22, "R6 pending");
    step(6);
    wr(1'b0, 32'h0);
    push(1, K_REQ, 0, "R10 cleared"); push(1, K_RD, 0, "R3 clear all");
    step(2);
    // R7 global enable low
    gie = 1'b0; irq_in[4] = 1'b0;
    step(4);
    irq_in[4] = 1'b1;
    push(5, K_REQ, 0, "R7 no request"); push(5, K_RD, 32'h10, "R7 still recorded");
    step(6);
    wr(1'b0, 32'hFFFF_FFFF);
    push(1, K_RD, 32'h10, "R3 write-one keeps");
    step(2);
    // R3 arrival on the same edge as a clear wins
    irq_in[6] = 1'b1;
    step(2);
    wr(1'b0, 32'h0);
    push(1, K_RD, 32'h40, "R3 arrival beats clear");
    step(2);
    wr(1'b0, 32'h0);
    step(2);
    gie = 1'b1;
    irq_in = '0;
    step(4);
    push(1, K_REQ, 0, "R10 idle");
    step(1);
    // R9 disabled controller: bypass pulse, pending untouched
    ctrl_en = 1'b0;
    irq_in[7] = 1'b1;
    push(3, K_REQ, 1, "R9 bypass request"); push(4, K_REQ, 0, "R9 one-cycle pulse");
    push(3, K_WAKE, 1, "R8 wake when disabled"); push(5, K_RD, 0, "R9 pending untouched");
    step(7);
    gie = 1'b0;
    irq_in[8] = 1'b1;
    push(3, K_REQ, 0, "R9 gie low no pulse"); push(3, K_WAKE, 1, "R8 wake gie low");
    step(6);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 scoreboard leftover actual=%0d expected=0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule